// File: doc/BRIEF.md
# Instant-Completion Command Register Block

This block is a memory-mapped register block that stands in for a bus controller. Software writes data buffer words and then sets a start bit in a command word. The block completes the command straight away. In that cycle it writes a fixed success code into the first transmit and the first receive buffer words, and it raises a completion flag. The completion flag is gated by an enable word, and software clears it by writing ones. No line timing, framing or checksum logic is modelled. The block gives software and driver tests a predictable partner.

Access uses a single word-addressed port. A write strobe takes effect at the clock edge where it is sampled. A read strobe returns the addressed word on `rdata` one cycle later. The window covers 32 words at byte offsets 0x00 to 0x7C, decoded from address bits [6:2]. An address with any higher bit set lies outside the window. A write there has no effect, and a read there returns zero. The interrupt output is a level, held high while the completion flag is set.

The command logic is a two-state machine.
- Its states are IDLE, where no completion is pending, and PENDING, where the completion flag is set.
- The named transitions are FIRE_SILENT (IDLE to IDLE: a start is accepted while the enable bit is clear) and FIRE_SIGNAL (IDLE to PENDING: a start is accepted while the enable bit is set).
- They are also FIRE_REFUSED (PENDING to PENDING: a start arrives while a completion is pending), FLAG_CLEARED (PENDING to IDLE: a status write with bit 0 set) and FLAG_KEPT (PENDING to PENDING: a status write with bit 0 clear).

Top module: `cmd_fire_regblock`

## Requirements
- R1: After reset every word reads zero, `irq` is low and `rdata` is zero.
- R2: A read strobe sampled at an edge puts the word as it stood before that edge on `rdata` after the edge. The value holds until the next read strobe. When a write to the same address falls in the same cycle, the read returns the old value.
- R3: Every in-window byte offset other than 0x08 (command) and 0x1C (status) is plain 32-bit storage and reads back the last value written. This includes 0x18, the enable word.
- R4: The command word at 0x08 always reads zero. A write to it with bit 0 clear changes no register and leaves `irq` unchanged.
- R5: An accepted start writes 0x00000040 into the transmit word at 0x20 and into the receive word at 0x30 at the same edge. A start is a write to 0x08 with bit 0 set while the status word is zero.
- R6: An accepted start loads the status word at 0x1C with bit 0 of the enable word, placed in bit 0. All other status bits stay zero. With enable bit 0 clear, the status stays zero and `irq` stays low, but the buffers are still loaded.
- R7: A start written while the status word is nonzero is refused. The buffer words and the status word keep their values.
- R8: A write to the status word clears every bit that is one in the write data and leaves the other bits as they were.
- R9: A write at a byte address of 0x80 or above changes no register, including the low word that shares its bits [6:2]. A read there returns zero.
- R10: `irq` is high exactly when the status word is nonzero.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous reset, active low |
| wr_en | input | 1 | Write strobe, one cycle per write |
| rd_en | input | 1 | Read strobe; data follows one cycle later |
| addr | input | ADDR_W (12) | Byte address, shared by reads and writes; bits [1:0] ignored |
| wdata | input | DATA_W (32) | Write data |
| rdata | output | DATA_W (32) | Registered read data |
| irq | output | 1 | Level interrupt, high while status is nonzero |

## Verification
Reads and writes share one address, so a read of a word can fall in the same cycle as a write that changes it. The sharpest case is a read of the status word in the same cycle as the write that clears it. The bench provokes this by asserting both strobes in one cycle. It first does so at the status word while a completion is pending, and then at the transmit word with new data. It expects the pre-write value on `rdata`, and a follow-up read must show the new value. The same bench also checks that `irq` falls at the edge where the clear is applied.

// File: rtl/cmdstub_pkg.sv
package cmdstub_pkg;

    localparam int unsigned WORDS  = 32;
    localparam int unsigned IDX_W  = $clog2(WORDS);

    typedef logic [IDX_W-1:0] widx_t;

    // word indices whose behaviour differs from plain storage
    localparam widx_t IDX_CMD = widx_t'(2);
    localparam widx_t IDX_IEN = widx_t'(6);
    localparam widx_t IDX_STS = widx_t'(7);
    localparam widx_t IDX_TX0 = widx_t'(8);
    localparam widx_t IDX_RX0 = widx_t'(12);

    localparam logic [7:0] DONE_CODE = 8'h40;

    typedef enum logic [0:0] {
        ST_IDLE    = 1'b0,
        ST_PENDING = 1'b1
    } cmd_state_t;

endpackage

// File: rtl/cmdstub_decode.sv
module cmdstub_decode
    import cmdstub_pkg::*;
#(
    parameter int unsigned ADDR_W = 12
) (
    input  logic              wr_en,
    input  logic [ADDR_W-1:0] addr,
    output logic              in_range,
    output widx_t             idx,
    output logic              wr_cmd,
    output logic              wr_sts,
    output logic              wr_plain
);

    localparam int unsigned LSB_HI = IDX_W + 2;

    logic unused_low;
    assign unused_low = ^addr[1:0];

    always_comb begin
        in_range = (addr[ADDR_W-1:LSB_HI] == '0);
        idx      = addr[LSB_HI-1:2];
        wr_cmd   = wr_en && in_range && (idx == IDX_CMD);
        wr_sts   = wr_en && in_range && (idx == IDX_STS);
        wr_plain = wr_en && in_range && (idx != IDX_CMD) && (idx != IDX_STS);
    end

endmodule

// File: rtl/cmdstub_ctrl.sv
module cmdstub_ctrl
    import cmdstub_pkg::*;
#(
    parameter int unsigned DATA_W = 32
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_cmd,
    input  logic              wr_sts,
    input  logic              wbit0,
    input  logic              en_done,
    output logic              load_code,
    output logic [DATA_W-1:0] sts,
    output logic              irq
);

    cmd_state_t state_q, state_d;
    logic       irq_q;

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q <= ST_IDLE;
            irq_q   <= 1'b0;
        end else begin
            state_q <= state_d;
            irq_q   <= (state_d == ST_PENDING);
        end
    end

    // next state and outputs
    always_comb begin
        state_d   = state_q;
        load_code = 1'b0;
        unique case (state_q)
            ST_IDLE: begin
                if (wr_cmd && wbit0) begin
                    load_code = 1'b1;              // FIRE_SILENT / FIRE_SIGNAL
                    if (en_done) state_d = ST_PENDING;
                end
            end
            ST_PENDING: begin
                // FIRE_REFUSED: start ignored here
                if (wr_sts && wbit0) state_d = ST_IDLE; // FLAG_CLEARED
            end
            default: state_d = ST_IDLE;
        endcase
    end

    assign sts = {{(DATA_W-1){1'b0}}, (state_q == ST_PENDING)};
    assign irq = irq_q;

endmodule

// File: rtl/cmdstub_store.sv
module cmdstub_store
    import cmdstub_pkg::*;
#(
    parameter int unsigned DATA_W = 32
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_plain,
    input  widx_t             idx,
    input  logic [DATA_W-1:0] wdata,
    input  logic              load_code,
    output logic [DATA_W-1:0] word_o [WORDS]
);

    localparam logic [DATA_W-1:0] CODE_W = {{(DATA_W-8){1'b0}}, DONE_CODE};

    for (genvar i = 0; i < int'(WORDS); i++) begin : g_word
        if (i == int'(IDX_CMD) || i == int'(IDX_STS)) begin : g_none
            assign word_o[i] = '0;
        end else if (i == int'(IDX_TX0) || i == int'(IDX_RX0)) begin : g_buf
            logic [DATA_W-1:0] q;
            always_ff @(posedge clk or negedge rst_n) begin
                if (!rst_n)                               q <= '0;
                else if (load_code)                       q <= CODE_W;
                else if (wr_plain && idx == widx_t'(i))   q <= wdata;
            end
            assign word_o[i] = q;
        end else begin : g_plain
            logic [DATA_W-1:0] q;
            always_ff @(posedge clk or negedge rst_n) begin
                if (!rst_n)                               q <= '0;
                else if (wr_plain && idx == widx_t'(i))   q <= wdata;
            end
            assign word_o[i] = q;
        end
    end

endmodule

// File: rtl/cmd_fire_regblock.sv
module cmd_fire_regblock
    import cmdstub_pkg::*;
#(
    parameter int unsigned ADDR_W = 12,
    parameter int unsigned DATA_W = 32
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_en,
    input  logic              rd_en,
    input  logic [ADDR_W-1:0] addr,
    input  logic [DATA_W-1:0] wdata,
    output logic [DATA_W-1:0] rdata,
    output logic              irq
);

    logic              in_range, wr_cmd, wr_sts, wr_plain, load_code;
    widx_t             idx;
    logic [DATA_W-1:0] sts_w;
    logic [DATA_W-1:0] word_w [WORDS];
    logic [DATA_W-1:0] tx0_w, rx0_w;
    logic [DATA_W-1:0] rdata_q;

    cmdstub_decode #(.ADDR_W(ADDR_W)) dec_i (
        .wr_en    (wr_en),
        .addr     (addr),
        .in_range (in_range),
        .idx      (idx),
        .wr_cmd   (wr_cmd),
        .wr_sts   (wr_sts),
        .wr_plain (wr_plain)
    );

    cmdstub_ctrl #(.DATA_W(DATA_W)) ctrl_i (
        .clk       (clk),
        .rst_n     (rst_n),
        .wr_cmd    (wr_cmd),
        .wr_sts    (wr_sts),
        .wbit0     (wdata[0]),
        .en_done   (word_w[IDX_IEN][0]),
        .load_code (load_code),
        .sts       (sts_w),
        .irq       (irq)
    );

    cmdstub_store #(.DATA_W(DATA_W)) store_i (
        .clk       (clk),
        .rst_n     (rst_n),
        .wr_plain  (wr_plain),
        .idx       (idx),
        .wdata     (wdata),
        .load_code (load_code),
        .word_o    (word_w)
    );

    assign tx0_w = word_w[IDX_TX0];
    assign rx0_w = word_w[IDX_RX0];

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            rdata_q <= '0;
        end else if (rd_en) begin
            if (!in_range)             rdata_q <= '0;
            else if (idx == IDX_STS)   rdata_q <= sts_w;
            else                       rdata_q <= word_w[idx];
        end
    end

    assign rdata = rdata_q;

endmodule

// File: rtl/cmd_fire_regblock_chk.sv
module cmd_fire_regblock_chk #(
    parameter int unsigned ADDR_W = 12,
    parameter int unsigned DATA_W = 32
) (
    input logic              clk,
    input logic              rst_n,
    input logic              wr_en,
    input logic              rd_en,
    input logic [ADDR_W-1:0] addr,
    input logic [DATA_W-1:0] wdata,
    input logic [DATA_W-1:0] rdata,
    input logic              irq,
    input logic [DATA_W-1:0] sts,
    input logic [DATA_W-1:0] tx0,
    input logic [DATA_W-1:0] rx0
);

    logic inwin, at_cmd, at_sts;
    assign inwin  = (addr[ADDR_W-1:7] == '0);
    assign at_cmd = inwin && (addr[6:2] == 5'd2);
    assign at_sts = inwin && (addr[6:2] == 5'd7);

    AST_IRQ_TRACKS_STATUS: assert property (@(posedge clk) disable iff (!rst_n)
        irq == (sts != '0)); // R10

    AST_FIRE_LOADS_CODE: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && at_cmd && wdata[0] && sts == '0)
        |=> (tx0 == 32'h40 && rx0 == 32'h40)); // R5

    AST_FIRE_REFUSED: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && at_cmd && wdata[0] && sts != '0)
        |=> ($stable(sts) && $stable(tx0) && $stable(rx0))); // R7

    AST_STATUS_W1C: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && at_sts) |=> (sts == ($past(sts) & ~$past(wdata)))); // R8

    AST_STATUS_ONLY_DONE: assert property (@(posedge clk) disable iff (!rst_n)
        (sts[DATA_W-1:1] == '0)); // R6

    AST_OUTSIDE_READ_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
        (rd_en && !inwin) |=> (rdata == '0)); // R9

endmodule

bind cmd_fire_regblock cmd_fire_regblock_chk #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) chk_i (
    .clk   (clk),
    .rst_n (rst_n),
    .wr_en (wr_en),
    .rd_en (rd_en),
    .addr  (addr),
    .wdata (wdata),
    .rdata (rdata),
    .irq   (irq),
    .sts   (sts_w),
    .tx0   (tx0_w),
    .rx0   (rx0_w)
);

// File: tb/cmd_fire_regblock_tb_top.sv
module cmd_fire_regblock_tb_top;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        wr_en = 1'b0;
    logic        rd_en = 1'b0;
    logic [11:0] addr = '0;
    logic [31:0] wdata = '0;
    logic [31:0] rdata;
    logic        irq;

    int checks = 0;
    int fails  = 0;
    bit done   = 1'b0;

    always #2 clk = ~clk;

    cmd_fire_regblock dut_i (
        .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .rd_en(rd_en),
        .addr(addr), .wdata(wdata), .rdata(rdata), .irq(irq)
    );

    task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    task automatic wr(input logic [11:0] a, input logic [31:0] d);
        @(negedge clk);
        wr_en = 1'b1; addr = a; wdata = d;
        @(negedge clk);
        wr_en = 1'b0;
    endtask

    task automatic rd(input logic [11:0] a, output logic [31:0] d);
        @(negedge clk);
        rd_en = 1'b1; addr = a;
        @(negedge clk);
        rd_en = 1'b0;
        d = rdata;
    endtask

    task automatic t_reset;
        logic [31:0] v;
        check("R1 rdata", rdata, 32'h0);
        check("R1 irq", {31'b0, irq}, 32'h0);
        for (int a = 0; a < 128; a += 4) begin
            rd(12'(a), v);
            check("R1 word", v, 32'h0);
        end
    endtask

    task automatic t_plain;
        logic [31:0] v;
        wr(12'h000, 32'hA5A5_0001); wr(12'h004, 32'h1234_5678);
        wr(12'h07C, 32'hFFFF_FFFF); wr(12'h018, 32'hF0F0_F0F0);
        rd(12'h000, v); check("R3 0x00", v, 32'hA5A5_0001);
        rd(12'h004, v); check("R3 0x04", v, 32'h1234_5678);
        rd(12'h07C, v); check("R3 0x7C", v, 32'hFFFF_FFFF);
        rd(12'h018, v); check("R3 0x18", v, 32'hF0F0_F0F0);
        check("R2 hold", rdata, 32'hF0F0_F0F0);
    endtask

    task automatic t_cmd_noop;
        logic [31:0] v;
        wr(12'h020, 32'h0000_1234);
        wr(12'h008, 32'hFFFF_FFFE);
        rd(12'h008, v); check("R4 cmd reads 0", v, 32'h0);
        rd(12'h020, v); check("R4 tx0 kept", v, 32'h0000_1234);
        check("R4 irq", {31'b0, irq}, 32'h0);
    endtask

    task automatic t_fire_masked;
        logic [31:0] v;
        wr(12'h018, 32'h0000_0000);
        wr(12'h020, 32'h0000_AAAA); wr(12'h030, 32'h0000_BBBB);
        wr(12'h008, 32'h0000_0001);
        check("R6 irq masked", {31'b0, irq}, 32'h0);
        rd(12'h020, v); check("R5 tx0", v, 32'h40);
        rd(12'h030, v); check("R5 rx0", v, 32'h40);
        rd(12'h01C, v); check("R6 sts masked", v, 32'h0);
        rd(12'h008, v); check("R4 cmd after fire", v, 32'h0);
    endtask

    task automatic t_fire_enabled;
        logic [31:0] v;
        wr(12'h018, 32'hFFFF_FFFF);
        wr(12'h020, 32'h0);
        wr(12'h008, 32'h0000_0001);
        check("R10 irq up", {31'b0, irq}, 32'h1);
        rd(12'h01C, v); check("R6 sts", v, 32'h1);
        rd(12'h020, v); check("R5 tx0 again", v, 32'h40);
    endtask

    task automatic t_reject;
        logic [31:0] v;
        wr(12'h020, 32'h0000_0055); wr(12'h030, 32'h0000_0066);
        wr(12'h008, 32'h0000_0001);
        rd(12'h020, v); check("R7 tx0", v, 32'h55);
        rd(12'h030, v); check("R7 rx0", v, 32'h66);
        rd(12'h01C, v); check("R7 sts", v, 32'h1);
    endtask

    task automatic t_w1c_collide;
        logic [31:0] v;
        wr(12'h01C, 32'hFFFF_FFFE);
        rd(12'h01C, v); check("R8 zeros keep", v, 32'h1);
        check("R10 irq kept", {31'b0, irq}, 32'h1);
        // read and clearing write in the same cycle
        @(negedge clk);
        wr_en = 1'b1; rd_en = 1'b1; addr = 12'h01C; wdata = 32'h1;
        @(negedge clk);
        wr_en = 1'b0; rd_en = 1'b0;
        check("R2 old status", rdata, 32'h1);
        check("R10 irq falls", {31'b0, irq}, 32'h0);
        rd(12'h01C, v); check("R8 cleared", v, 32'h0);
        // same cycle on a plain word
        @(negedge clk);
        wr_en = 1'b1; rd_en = 1'b1; addr = 12'h020; wdata = 32'hCAFE_0000;
        @(negedge clk);
        wr_en = 1'b0; rd_en = 1'b0;
        check("R2 old tx0", rdata, 32'h55);
        rd(12'h020, v); check("R2 new tx0", v, 32'hCAFE_0000);
    endtask

    task automatic t_outside;
        logic [31:0] v;
        wr(12'h000, 32'h1111_1111);
        wr(12'h080, 32'hDEAD_BEEF);
        wr(12'h088, 32'h0000_0001);   // would alias the command word
        rd(12'h000, v); check("R9 no alias", v, 32'h1111_1111);
        rd(12'h020, v); check("R9 no fire", v, 32'hCAFE_0000);
        check("R9 irq", {31'b0, irq}, 32'h0);
        rd(12'h080, v); check("R9 read 0x80", v, 32'h0);
        rd(12'hFFC, v); check("R9 read top", v, 32'h0);
    endtask

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        t_reset();
        t_plain();
        t_cmd_noop();
        t_fire_masked();
        t_fire_enabled();
        t_reject();
        t_w1c_collide();
        t_outside();
        if (!done) begin
            done = 1'b1;
            $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
            $finish;
        end
    end

    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            done = 1'b1;
            checks++; fails++;
            $display("FAIL watchdog actual=hung expected=finished");
            $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
            $finish;
        end
    end

endmodule